// File: doc/BRIEF.md
# Long-Descriptor Page Table Walker

This block translates a 48-bit virtual address into an intermediate physical address by walking a tree of 64-bit long-format descriptors held in memory. The caller has already chosen the translation base, the granule (4K, 16K or 64K), the starting level (0 to 3) and the configured output size. It hands these over with one request. The walker then fetches one descriptor per level over a plain request/response memory port. It follows table descriptors downward until it reaches a leaf or a fault condition. It returns the translated address together with write and execute permission, or a fault.

Restrictions found in table descriptors are gathered as the walk descends and applied at the leaf. Every returned descriptor is checked before it is interpreted. It must not carry base bits above the configured output size, and with the 64K granule it must keep its low four base bits clear. A memory read error ends the walk at once.

The controller has four states. IDLE waits for a request and moves to ISSUE when one is accepted. ISSUE drives the descriptor read for one cycle and always moves to WAIT. WAIT holds until a response arrives. From WAIT the walker goes back to ISSUE when the descriptor is a valid table entry that passes all checks, and goes to DONE otherwise. DONE raises the completion pulse for one cycle and returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 and done and mem_req_valid are 0.
- R2: Granule code 0 selects 4K (page shift 12), 1 selects 16K (shift 14), 2 selects 64K (shift 16), and code 3 acts as 4K. Each read address is formed in three steps. First, the current table base is cleared below the page shift s. Second, an index of s-3 bits is taken from the virtual address starting at bit s+(s-3)*(3-level). Third, that index is shifted left by 3 and ORed into the cleared base. The starting table base is req_base with bits below s cleared.
- R3: Descriptor bits [1:0] carry the type. When they read 11 below level 3, the entry is a table: the level increments, and the next base is descriptor bits [47:s]. The walk stops at level 3, at an entry with bit 0 clear, or at a block (01 below level 3).
- R4: A leaf is either a block (01 below level 3) or a page (11 at level 3). On a leaf, out_paddr is descriptor bits [47:s] ORed with the virtual address bits below s+(s-3)*(3-level).
- R5: An entry with bit 0 clear, or 01 at level 3, produces a fault. On a fault, out_paddr, out_write and out_exec are all 0.
- R6: Any returned descriptor with a base bit set in [47:osize] produces a fault, where osize is the configured output size and is below 48.
- R7: With the 64K granule, a returned descriptor with any of bits [15:12] set produces a fault.
- R8: Each table descriptor ORs its bit 60 into a sticky execute-never flag and its bit 62 into a sticky read-only flag. out_write is 1 only when neither the leaf bit 7 nor the sticky read-only flag is set. out_exec is 1 only when neither the leaf bit 54 nor the sticky execute-never flag is set.
- R9: A response with mem_rsp_err set ends the walk with a fault.
- R10: A request is taken only while req_ready is 1, and req_valid has no effect during a walk. The done pulse lasts one cycle. A walk of N reads raises done 2N+1 cycles after the accepting edge, provided each response arrives one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_base | input | 48 | Starting table base |
| req_gran | input | 2 | Granule code |
| req_level | input | 2 | Starting level |
| req_osize | input | 6 | Output size in bits (up to 48) |
| mem_req_valid | output | 1 | Descriptor read strobe, one cycle |
| mem_req_addr | output | 48 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor |
| mem_rsp_err | input | 1 | Read error |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Walk ended in fault (valid with done) |
| out_paddr | output | 48 | Translated address |
| out_write | output | 1 | Write permitted |
| out_exec | output | 1 | Execute permitted |

## Verification
The bench memory model answers each read on the cycle after the read is strobed. Under that model every read costs two cycles, and done is due on the (2N+1)-th falling edge after the edge that accepted the request. Each scenario counts falling edges from acceptance and compares the count against 2N+1, using the number of reads that scenario's table layout must cause. Result fields are sampled on that same falling edge. Read addresses are logged at the falling edge of the strobe cycle. The absence of a second pulse or of extra reads is checked on the edges that follow.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    // descriptor attribute bit positions
    localparam int DB_RO_LEAF = 7;
    localparam int DB_XN_LEAF = 54;
    localparam int DB_XN_TBL  = 60;
    localparam int DB_RO_TBL  = 62;
    localparam int DB_BASE_LO = 12;

    // page shift per granule code; code 3 falls back to 4K
    function automatic logic [4:0] page_shift(input logic [1:0] gran);
        case (gran)
            2'd1:    return 5'd14;
            2'd2:    return 5'd16;
            default: return 5'd12;
        endcase
    endfunction

endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [1:0]        gran,
    input  logic [1:0]        level,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [ADDR_W-1:0] offs_mask
);
    logic [4:0]        shift;
    logic [4:0]        stride;
    logic [6:0]        lsb;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        shift     = page_shift(gran);
        stride    = shift - 5'd3;
        lsb       = 7'(shift) + 7'(stride) * 7'(2'd3 - level);
        idx       = (vaddr >> lsb) & ((ADDR_W'(1) << stride) - ADDR_W'(1));
        desc_addr = table_base | (idx << 3);
        offs_mask = (ADDR_W'(1) << lsb) - ADDR_W'(1);
    end
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DESC_W = 64,
    parameter int OSZ_W  = 6
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        gran,
    input  logic [1:0]        level,
    input  logic [OSZ_W-1:0]  osize,
    output logic              bad_size,
    output logic              bad_align,
    output logic              is_table,
    output logic              is_leaf,
    output logic [ADDR_W-1:0] next_base,
    output logic              tbl_ro,
    output logic              tbl_xn,
    output logic              leaf_ro,
    output logic              leaf_xn
);
    logic [ADDR_W-1:0] raw_base;
    logic [ADDR_W-1:0] hi_mask;
    logic              at_last;

    always_comb begin
        raw_base  = {desc[ADDR_W-1:DB_BASE_LO], {DB_BASE_LO{1'b0}}};
        hi_mask   = (int'(osize) >= ADDR_W) ? '0
                  : ~((ADDR_W'(1) << osize) - ADDR_W'(1));
        bad_size  = |(raw_base & hi_mask);
        bad_align = (gran == 2'd2) && (|desc[DB_BASE_LO+3:DB_BASE_LO]);
        at_last   = (level == 2'd3);
        is_table  = (desc[1:0] == 2'b11) && !at_last;
        is_leaf   = ((desc[1:0] == 2'b01) && !at_last) ||
                    ((desc[1:0] == 2'b11) && at_last);
        next_base = raw_base & ~((ADDR_W'(1) << page_shift(gran)) - ADDR_W'(1));
        tbl_ro    = desc[DB_RO_TBL];
        tbl_xn    = desc[DB_XN_TBL];
        leaf_ro   = desc[DB_RO_LEAF];
        leaf_xn   = desc[DB_XN_LEAF];
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter  int ADDR_W = 48,
    parameter  int DESC_W = 64,
    localparam int OSZ_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [1:0]        req_gran,
    input  logic [1:0]        req_level,
    input  logic [OSZ_W-1:0]  req_osize,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] out_paddr,
    output logic              out_write,
    output logic              out_exec
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] va_q, base_q, pa_q;
    logic [1:0]        gran_q, level_q;
    logic [OSZ_W-1:0]  osize_q;
    logic              ro_q, xn_q, fault_q, wr_q, ex_q;

    logic [ADDR_W-1:0] daddr, offs_mask, next_base, start_mask;
    logic bad_size, bad_align, is_table, is_leaf;
    logic tbl_ro, tbl_xn, leaf_ro, leaf_xn, stop_fault;

    ptw_index #(.ADDR_W(ADDR_W)) u_index (
        .vaddr      (va_q),
        .table_base (base_q),
        .gran       (gran_q),
        .level      (level_q),
        .desc_addr  (daddr),
        .offs_mask  (offs_mask)
    );

    ptw_decode #(.ADDR_W(ADDR_W), .DESC_W(DESC_W), .OSZ_W(OSZ_W)) u_decode (
        .desc      (mem_rsp_data),
        .gran      (gran_q),
        .level     (level_q),
        .osize     (osize_q),
        .bad_size  (bad_size),
        .bad_align (bad_align),
        .is_table  (is_table),
        .is_leaf   (is_leaf),
        .next_base (next_base),
        .tbl_ro    (tbl_ro),
        .tbl_xn    (tbl_xn),
        .leaf_ro   (leaf_ro),
        .leaf_xn   (leaf_xn)
    );

    assign start_mask = ~((ADDR_W'(1) << page_shift(req_gran)) - ADDR_W'(1));
    assign stop_fault = mem_rsp_err | bad_size | bad_align;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_d = (!stop_fault && is_table) ? ST_ISSUE : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            base_q  <= '0;
            gran_q  <= '0;
            level_q <= '0;
            osize_q <= '0;
            ro_q    <= 1'b0;
            xn_q    <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
            wr_q    <= 1'b0;
            ex_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q    <= req_vaddr;
                base_q  <= req_base & start_mask;
                gran_q  <= req_gran;
                level_q <= req_level;
                osize_q <= req_osize;
                ro_q    <= 1'b0;
                xn_q    <= 1'b0;
            end else if (state_q == ST_WAIT && mem_rsp_valid) begin
                if (!stop_fault && is_table) begin
                    base_q  <= next_base;
                    level_q <= level_q + 2'd1;
                    ro_q    <= ro_q | tbl_ro;
                    xn_q    <= xn_q | tbl_xn;
                end else if (!stop_fault && is_leaf) begin
                    fault_q <= 1'b0;
                    pa_q    <= next_base | (va_q & offs_mask);
                    wr_q    <= !(leaf_ro | ro_q);
                    ex_q    <= !(leaf_xn | xn_q);
                end else begin
                    fault_q <= 1'b1;
                    pa_q    <= '0;
                    wr_q    <= 1'b0;
                    ex_q    <= 1'b0;
                end
            end
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = daddr;
    assign done          = (state_q == ST_DONE);
    assign fault         = fault_q;
    assign out_paddr     = pa_q;
    assign out_write     = wr_q;
    assign out_exec      = ex_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic              done,
    input logic              fault,
    input logic [ADDR_W-1:0] out_paddr,
    input logic              out_write,
    input logic              out_exec
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R10
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10
    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid)); // R3
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!out_write && !out_exec && out_paddr == '0)); // R5
    AST_ERR_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_err && !req_ready && !mem_req_valid && !done)
        |=> (done && fault)); // R9
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .fault         (fault),
    .out_paddr     (out_paddr),
    .out_write     (out_write),
    .out_exec      (out_exec)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0, req_base = '0;
    logic [1:0]  req_gran = '0, req_level = '0;
    logic [5:0]  req_osize = 6'd48;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done, fault, out_write, out_exec;
    logic [47:0] out_paddr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_base(req_base),
        .req_gran(req_gran), .req_level(req_level), .req_osize(req_osize),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err),
        .done(done), .fault(fault), .out_paddr(out_paddr),
        .out_write(out_write), .out_exec(out_exec)
    );

    // memory model: answers one cycle after the strobe
    logic [63:0] mem [logic [47:0]];
    logic        err_en = 1'b0;
    logic [47:0] err_addr = '0;
    logic        pend = 1'b0;
    logic [47:0] pend_addr = '0;
    logic [47:0] addr_log [0:7];
    int          n_rd = 0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_rsp_data  = '0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            mem_rsp_err   = err_en && (pend_addr == err_addr);
            pend = 1'b0;
        end
        if (mem_req_valid) begin
            pend = 1'b1;
            pend_addr = mem_req_addr;
            if (n_rd < 8) addr_log[n_rd] = mem_req_addr;
            n_rd++;
        end
    end

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic int shift_of(input int g);
        return (g == 1) ? 14 : (g == 2) ? 16 : 12;
    endfunction

    function automatic logic [47:0] exp_daddr(input logic [47:0] b, input logic [47:0] va,
                                              input int g, input int lvl);
        int sh = shift_of(g);
        int lsb = sh + (sh - 3) * (3 - lvl);
        logic [47:0] bm = b & ~((48'd1 << sh) - 48'd1);
        logic [47:0] idx = (va >> lsb) & ((48'd1 << (sh - 3)) - 48'd1);
        return bm | (idx << 3);
    endfunction

    function automatic logic [47:0] exp_low(input logic [47:0] va, input int g, input int lvl);
        int sh = shift_of(g);
        int lsb = sh + (sh - 3) * (3 - lvl);
        return va & ((48'd1 << lsb) - 48'd1);
    endfunction

    // issue one request, return falling edges until done
    task automatic walk(input logic [47:0] va, input logic [47:0] base, input logic [1:0] g,
                        input logic [1:0] lvl, input logic [5:0] os, output int lat);
        @(negedge clk);
        n_rd = 0;
        req_valid = 1'b1; req_vaddr = va; req_base = base;
        req_gran = g; req_level = lvl; req_osize = os;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_ok(input string rq, input int lat, input int reads,
                             input logic [47:0] pa, input logic w, input logic x);
        check("R10", {rq, " latency"}, 64'(lat), 64'(2 * reads + 1));
        check(rq, "fault", 64'(fault), 64'd0);
        check(rq, "paddr", 64'(out_paddr), 64'(pa));
        check("R8", {rq, " write"}, 64'(out_write), 64'(w));
        check("R8", {rq, " exec"}, 64'(out_exec), 64'(x));
    endtask

    task automatic expect_fault(input string rq, input int lat, input int reads);
        check("R10", {rq, " latency"}, 64'(lat), 64'(2 * reads + 1));
        check(rq, "fault", 64'(fault), 64'd1);
        check("R5", {rq, " paddr cleared"}, 64'(out_paddr), 64'd0);
    endtask

    task automatic t_reset();
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        check("R1", "done", 64'(done), 64'd0);
        check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    // R2 R3 R4: four-level 4K walk to a page, unaligned start base
    task automatic t_four_level();
        logic [47:0] va = 48'h7F12_3456_7ABC;
        logic [47:0] a0, a1, a2, a3;
        int lat;
        mem.delete();
        a0 = exp_daddr(48'h0010_0000, va, 0, 0);
        a1 = exp_daddr(48'h0020_0000, va, 0, 1);
        a2 = exp_daddr(48'h0030_0000, va, 0, 2);
        a3 = exp_daddr(48'h0040_0000, va, 0, 3);
        mem[a0] = 64'h0020_0003;
        mem[a1] = 64'h0030_0003;
        mem[a2] = 64'h0040_0003;
        mem[a3] = 64'h00AB_CDEF_0003;
        walk(va, 48'h0010_0123, 2'd0, 2'd0, 6'd48, lat);
        expect_ok("R4", lat, 4, 48'h00AB_CDEF_0ABC, 1'b1, 1'b1);
        check("R2", "read0 addr", 64'(addr_log[0]), 64'(a0));
        check("R2", "read1 addr", 64'(addr_log[1]), 64'(a1));
        check("R3", "read2 addr", 64'(addr_log[2]), 64'(a2));
        check("R3", "read3 addr", 64'(addr_log[3]), 64'(a3));
    endtask

    // R3 R4: block at level 2 stops the walk
    task automatic t_block();
        logic [47:0] va = 48'h0000_4060_1234;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h0050_0000, va, 0, 1)] = 64'h0060_0003;
        mem[exp_daddr(48'h0060_0000, va, 0, 2)] = 64'h8000_0001;
        walk(va, 48'h0050_0000, 2'd0, 2'd1, 6'd48, lat);
        expect_ok("R3", lat, 2, 48'h8000_0000 | exp_low(va, 0, 2), 1'b1, 1'b1);
        check("R3", "reads", 64'(n_rd), 64'd2);
    endtask

    // R8: 16K two-level walk with given table/leaf attributes
    task automatic t_perm(input logic [63:0] tattr, input logic [63:0] lattr,
                          input logic w, input logic x);
        logic [47:0] va = 48'h0000_0123_4567;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h0070_0000, va, 1, 2)] = 64'h0074_0003 | tattr;
        mem[exp_daddr(48'h0074_0000, va, 1, 3)] = 64'h0012_3456_C003 | lattr;
        walk(va, 48'h0070_0000, 2'd1, 2'd2, 6'd48, lat);
        expect_ok("R8", lat, 2, 48'h0012_3456_C567, w, x);
    endtask

    // R7: 64K walk, aligned then misaligned table base
    task automatic t_64k();
        logic [47:0] va = 48'h0000_1234_5678;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h0090_0000, va, 2, 2)] = 64'h00A0_0003;
        mem[exp_daddr(48'h00A0_0000, va, 2, 3)] = 64'h5555_0003;
        walk(va, 48'h0090_0000, 2'd2, 2'd2, 6'd48, lat);
        expect_ok("R7", lat, 2, 48'h5555_5678, 1'b1, 1'b1);
        mem[exp_daddr(48'h0090_0000, va, 2, 2)] = 64'h00A0_1003;
        walk(va, 48'h0090_0000, 2'd2, 2'd2, 6'd48, lat);
        expect_fault("R7", lat, 1);
    endtask

    // R6: leaf base bit 44 against output sizes 40 and 48
    task automatic t_osize();
        logic [47:0] va = 48'h0000_0000_0F21;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h00B0_0000, va, 0, 3)] = 64'h1000_0000_0003;
        walk(va, 48'h00B0_0000, 2'd0, 2'd3, 6'd40, lat);
        expect_fault("R6", lat, 1);
        walk(va, 48'h00B0_0000, 2'd0, 2'd3, 6'd48, lat);
        expect_ok("R6", lat, 1, 48'h1000_0000_0F21, 1'b1, 1'b1);
        mem[exp_daddr(48'h00B0_0000, va, 0, 2)] = 64'h0100_0000_0003;
        walk(va, 48'h00B0_0000, 2'd0, 2'd2, 6'd40, lat);
        expect_fault("R6", lat, 1);
    endtask

    // R5: invalid and reserved encodings
    task automatic t_invalid();
        logic [47:0] va = 48'h0000_2222_3333;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h00C0_0000, va, 0, 1)] = 64'h00D0_0000;
        walk(va, 48'h00C0_0000, 2'd0, 2'd1, 6'd48, lat);
        expect_fault("R5", lat, 1);
        mem[exp_daddr(48'h00C0_0000, va, 0, 1)] = 64'h00D0_0002;
        walk(va, 48'h00C0_0000, 2'd0, 2'd1, 6'd48, lat);
        expect_fault("R5", lat, 1);
        mem[exp_daddr(48'h00C0_0000, va, 0, 3)] = 64'h00D0_0001;
        walk(va, 48'h00C0_0000, 2'd0, 2'd3, 6'd48, lat);
        expect_fault("R5", lat, 1);
    endtask

    // R9: read error on the second level
    task automatic t_mem_err();
        logic [47:0] va = 48'h0000_4060_1234;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h0050_0000, va, 0, 1)] = 64'h0060_0003;
        mem[exp_daddr(48'h0060_0000, va, 0, 2)] = 64'h8000_0001;
        err_en = 1'b1;
        err_addr = exp_daddr(48'h0060_0000, va, 0, 2);
        walk(va, 48'h0050_0000, 2'd0, 2'd1, 6'd48, lat);
        err_en = 1'b0;
        expect_fault("R9", lat, 2);
    endtask

    // R2: granule code 3 acts as 4K
    task automatic t_gran3();
        logic [47:0] va = 48'h0000_0ABC_DEF9;
        logic [47:0] a;
        int lat;
        mem.delete();
        a = exp_daddr(48'h00E0_0000, va, 0, 3);
        mem[a] = 64'h0077_7000_0003;
        walk(va, 48'h00E0_0000, 2'd3, 2'd3, 6'd48, lat);
        expect_ok("R2", lat, 1, 48'h0077_7000_0EF9, 1'b1, 1'b1);
        check("R2", "gran3 addr", 64'(addr_log[0]), 64'(a));
    endtask

    // R10: request while busy is ignored, single done pulse
    task automatic t_busy();
        logic [47:0] va = 48'h0000_0000_5123;
        int lat;
        mem.delete();
        mem[exp_daddr(48'h00F0_0000, va, 0, 2)] = 64'h0100_0003;
        mem[exp_daddr(48'h0100_0000, va, 0, 3)] = 64'h0003_3000_0003;
        @(negedge clk);
        n_rd = 0;
        req_valid = 1'b1; req_vaddr = va; req_base = 48'h00F0_0000;
        req_gran = 2'd0; req_level = 2'd2; req_osize = 6'd48;
        @(negedge clk);
        lat = 1;
        check("R10", "ready low while busy", 64'(req_ready), 64'd0);
        req_vaddr = 48'h0000_7777_7000;
        @(negedge clk); lat++;
        @(negedge clk); lat++;
        req_valid = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        expect_ok("R10", lat, 2, 48'h0003_3000_0123, 1'b1, 1'b1);
        @(negedge clk);
        check("R10", "done one cycle", 64'(done), 64'd0);
        @(negedge clk);
        @(negedge clk);
        check("R10", "no extra reads", 64'(n_rd), 64'd2);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four_level();
        t_block();
        t_perm(64'h4000_0000_0000_0000, 64'h0040_0000_0000_0000, 1'b0, 1'b0);
        t_perm(64'h1000_0000_0000_0000, 64'h0, 1'b1, 1'b0);
        t_perm(64'h0, 64'h80, 1'b0, 1'b1);
        t_64k();
        t_osize();
        t_invalid();
        t_mem_err();
        t_gran3();
        t_busy();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule